// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

This block merges two groups of pending interrupt requests into one priority level every cycle. One group comes from software and one from external hardware lines. It compares that level with a locally held current priority level. When the pending level is strictly higher, it issues a one-cycle trap request. In the same cycle it captures a snapshot of every pending source and the winning level, so the trap handler can read them.

The two groups share one level space. A software request at bit position i resolves to level i minus three, so bits 4 to 18 give levels 1 to 15. An external request at bit position i resolves to level i. Within a group the highest set bit wins. Any external request outranks all software requests.

Once a trap has been issued, the block holds its snapshot until the consumer acknowledges it. A pending asynchronous-trap request is not serviced. It only raises an error flag.

Top module: `irq_level_resolver`

## Requirements
- R1: Only software request bits 4 through 18 (mask 0x7fff0) take part. All other software bits are ignored and never cause a trap or appear in the summary.
- R2: A pending software bit i resolves to level i-3. Bit 4 gives level 1 and bit 18 gives level 15.
- R3: An external bit i in the range 20 through 31 resolves to level i. External bits 0 through 19 are ignored.
- R4: Within each group the highest pending bit sets the level. When any external bit is pending, the external level wins over every software request.
- R5: On a trap, `sum_o` holds every pending, accepted bit of both groups at its own bit position.
- R6: A trap is raised only when the resolved level is nonzero and strictly greater than `ipl_o`. An equal level gives no trap.
- R7: `trap_o` is high for exactly one cycle, on the clock after the inputs that caused it. `sum_o` and `id_o` take their new values in that same cycle.
- R8: After a trap, no further trap is raised and `sum_o`/`id_o` hold until `trap_ack` is sampled high. The earliest next trap appears one cycle after that sampling edge.
- R9: A write on `ipl_wr` loads the low 5 bits of `ipl_wdata` into the priority level. The new value is visible on `ipl_o`, and used for comparison, from the next cycle.
- R10: `async_err` is a registered flag that is high one cycle after any bit of the 4-bit `ast_req` is set, and low otherwise.
- R11: Reset clears `trap_o`, `sum_o`, `id_o`, `ipl_o` and `async_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 32 | Software interrupt request vector |
| ext_pend | input | 32 | External interrupt status vector |
| ast_req | input | 4 | Asynchronous-trap request bits |
| ipl_wr | input | 1 | Priority level write strobe |
| ipl_wdata | input | 32 | Priority level write data |
| trap_ack | input | 1 | Consumer acknowledges the outstanding trap |
| trap_o | output | 1 | One-cycle trap request |
| sum_o | output | 32 | Captured pending-source summary |
| id_o | output | 5 | Captured winning level |
| ipl_o | output | 5 | Current priority level |
| async_err | output | 1 | Unsupported asynchronous-trap request flag |

## Verification
A wrong internal state always shows up at the ports within one cycle. A corrupted priority level appears directly on `ipl_o`. A broken scan or bias gives the wrong `id_o` on the trap cycle. A stuck outstanding-trap flag either suppresses the trap expected one cycle after an acknowledge, or lets a second trap through while unacknowledged. The bench compares every output on every cycle against a model built from the requirements. Equal-level and held-without-acknowledge sequences catch off-by-one comparisons and a missing hold.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
   localparam int VEC_W_DEF  = 32;
   localparam int LVL_W_DEF  = 5;
   localparam int SW_LO_DEF  = 4;
   localparam int SW_HI_DEF  = 18;
   localparam int EXT_LO_DEF = 20;
   localparam int EXT_HI_DEF = 31;
   localparam int AST_W_DEF  = 4;

   typedef enum logic {ARM_IDLE = 1'b0, ARM_WAIT_ACK = 1'b1} arm_state_e;
endpackage

// File: rtl/irq_group_scan.sv
module irq_group_scan #(
   parameter int VEC_W = 32,
   parameter int LVL_W = 5,
   parameter int LO    = 4,
   parameter int HI    = 18,
   parameter int BIAS  = 3
) (
   input  logic [VEC_W-1:0] vec,
   output logic [VEC_W-1:0] kept,
   output logic             hit,
   output logic [LVL_W-1:0] lvl
);
   if (LO < 0 || HI >= VEC_W || LO > HI) begin : g_bad_range
      $error("irq_group_scan: bit range out of vector");
   end
   if (HI - BIAS > (1 << LVL_W) - 1 || LO - BIAS < 1) begin : g_bad_level
      $error("irq_group_scan: levels do not fit level width");
   end

   for (genvar gi = 0; gi < VEC_W; gi++) begin : g_keep
      if (gi >= LO && gi <= HI) begin : g_in
         assign kept[gi] = vec[gi];
      end else begin : g_out
         assign kept[gi] = 1'b0;
      end
   end

   assign hit = |kept;

   always_comb begin
      lvl = '0;
      for (int i = LO; i <= HI; i++) begin
         if (vec[i]) lvl = LVL_W'(i - BIAS);
      end
   end
endmodule

// File: rtl/irq_ipl_reg.sv
module irq_ipl_reg #(
   parameter int DATA_W = 32,
   parameter int LVL_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [LVL_W-1:0]  q
);
   if (LVL_W > DATA_W) begin : g_bad_w
      $error("irq_ipl_reg: level wider than write data");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= wdata[LVL_W-1:0];
   end

   AST_IPL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (q == $past(wdata[LVL_W-1:0]))); // R9
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
   import irq_res_pkg::*;
#(
   parameter int VEC_W  = VEC_W_DEF,
   parameter int LVL_W  = LVL_W_DEF,
   parameter int SW_LO  = SW_LO_DEF,
   parameter int SW_HI  = SW_HI_DEF,
   parameter int EXT_LO = EXT_LO_DEF,
   parameter int EXT_HI = EXT_HI_DEF,
   parameter int AST_W  = AST_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VEC_W-1:0] sw_req,
   input  logic [VEC_W-1:0] ext_pend,
   input  logic [AST_W-1:0] ast_req,
   input  logic             ipl_wr,
   input  logic [VEC_W-1:0] ipl_wdata,
   input  logic             trap_ack,
   output logic             trap_o,
   output logic [VEC_W-1:0] sum_o,
   output logic [LVL_W-1:0] id_o,
   output logic [LVL_W-1:0] ipl_o,
   output logic             async_err
);
   localparam int SW_BIAS  = SW_LO - 1;
   localparam int EXT_BIAS = 0;

   if (SW_HI >= EXT_LO) begin : g_overlap
      $error("irq_level_resolver: software and external ranges overlap");
   end

   logic [VEC_W-1:0] sw_kept, ext_kept;
   logic             sw_hit, ext_hit;
   logic [LVL_W-1:0] sw_lvl, ext_lvl, win_lvl;
   logic             fire;
   arm_state_e       arm_q;

   irq_group_scan #(.VEC_W(VEC_W), .LVL_W(LVL_W), .LO(SW_LO), .HI(SW_HI),
                    .BIAS(SW_BIAS)) u_sw_scan (
      .vec(sw_req), .kept(sw_kept), .hit(sw_hit), .lvl(sw_lvl));

   irq_group_scan #(.VEC_W(VEC_W), .LVL_W(LVL_W), .LO(EXT_LO), .HI(EXT_HI),
                    .BIAS(EXT_BIAS)) u_ext_scan (
      .vec(ext_pend), .kept(ext_kept), .hit(ext_hit), .lvl(ext_lvl));

   irq_ipl_reg #(.DATA_W(VEC_W), .LVL_W(LVL_W)) u_ipl (
      .clk(clk), .rst_n(rst_n), .wr(ipl_wr), .wdata(ipl_wdata), .q(ipl_o));

   always_comb begin
      if (ext_hit)     win_lvl = ext_lvl;
      else if (sw_hit) win_lvl = sw_lvl;
      else             win_lvl = '0;
   end

   assign fire = (win_lvl != '0) && (win_lvl > ipl_o) && (arm_q == ARM_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q     <= ARM_IDLE;
         trap_o    <= 1'b0;
         sum_o     <= '0;
         id_o      <= '0;
         async_err <= 1'b0;
      end else begin
         trap_o    <= fire;
         async_err <= |ast_req;
         if (fire) begin
            sum_o <= sw_kept | ext_kept;
            id_o  <= win_lvl;
            arm_q <= ARM_WAIT_ACK;
         end else if (trap_ack) begin
            arm_q <= ARM_IDLE;
         end
      end
   end

   AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |=> !trap_o); // R7
   AST_TRAP_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (id_o > $past(ipl_o))); // R6
   AST_ID_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (id_o != '0)); // R6
   AST_HOLD_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_o |-> ($stable(id_o) && $stable(sum_o))); // R8
   AST_ASYNC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (|ast_req) |=> async_err); // R10
endmodule

// File: tb/irq_level_resolver_test.sv
module irq_level_resolver_test;
   localparam realtime HALF = 4ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] sw_req = '0, ext_pend = '0, ipl_wdata = '0;
   logic [3:0]  ast_req = '0;
   logic        ipl_wr = 1'b0, trap_ack = 1'b0;
   logic        trap_o, async_err;
   logic [31:0] sum_o;
   logic [4:0]  id_o, ipl_o;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      logic        trap;
      logic [31:0] sum;
      logic [4:0]  id;
      logic [4:0]  ipl;
      logic        err;
      string       tag;
   } exp_t;

   exp_t scb[$];

   logic [31:0] m_sum = '0;
   logic [4:0]  m_id = '0, m_ipl = '0;
   logic        m_busy = 1'b0;

   always #HALF clk = ~clk;

   irq_level_resolver uut (
      .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .ext_pend(ext_pend),
      .ast_req(ast_req), .ipl_wr(ipl_wr), .ipl_wdata(ipl_wdata),
      .trap_ack(trap_ack), .trap_o(trap_o), .sum_o(sum_o), .id_o(id_o),
      .ipl_o(ipl_o), .async_err(async_err));

   task automatic compare(input exp_t e);
      n_cmp++;
      if (trap_o !== e.trap || sum_o !== e.sum || id_o !== e.id ||
          ipl_o !== e.ipl || async_err !== e.err) begin
         n_bad++;
         $display("FAIL %s: actual trap=%0b sum=%h id=%0d ipl=%0d err=%0b expected trap=%0b sum=%h id=%0d ipl=%0d err=%0b",
                  e.tag, trap_o, sum_o, id_o, ipl_o, async_err,
                  e.trap, e.sum, e.id, e.ipl, e.err);
      end
   endtask

   // Driver: applies one cycle of stimulus and predicts the outputs after the next edge.
   task automatic step(input logic [31:0] sw, input logic [31:0] ext,
                       input logic [3:0] ast, input logic ack,
                       input logic wr, input logic [31:0] wd, input string tag);
      logic [31:0] swm, extm;
      logic [4:0]  lvl;
      logic        fire;
      exp_t        e;
      @(negedge clk);
      sw_req = sw; ext_pend = ext; ast_req = ast; trap_ack = ack;
      ipl_wr = wr; ipl_wdata = wd;
      swm  = sw & 32'h0007_FFF0;
      extm = ext & 32'hFFF0_0000;
      lvl  = '0;
      for (int i = 4; i <= 18; i++) if (swm[i]) lvl = 5'(i - 3);
      for (int i = 20; i <= 31; i++) if (extm[i]) lvl = 5'(i);
      fire = (lvl != 0) && (lvl > m_ipl) && !m_busy;
      if (fire) begin
         m_sum = swm | extm; m_id = lvl; m_busy = 1'b1;
      end else if (ack) begin
         m_busy = 1'b0;
      end
      if (wr) m_ipl = wd[4:0];
      e.trap = fire; e.sum = m_sum; e.id = m_id; e.ipl = m_ipl;
      e.err = |ast; e.tag = tag;
      scb.push_back(e);
   endtask

   // Monitor: pops one prediction per clock edge and compares it.
   initial begin
      forever begin
         @(posedge clk);
         #2ns;
         if (scb.size() > 0) compare(scb.pop_front());
      end
   end

   initial begin
      #(HALF * 2 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      exp_t r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      r.trap = 0; r.sum = '0; r.id = '0; r.ipl = '0; r.err = 0; r.tag = "R11 reset";
      compare(r);
      // R1: software bits outside 4..18 ignored
      step(32'h0008_000F, 0, 0, 0, 0, 0, "R1 out-of-range sw");
      step(0, 0, 0, 0, 0, 0, "R1 idle");
      // R2: lowest software level, then hold without ack (R8)
      step(32'h0000_0010, 0, 0, 0, 0, 0, "R2 bit4 level1");
      step(32'h0000_0010, 0, 0, 0, 0, 0, "R8 held no ack");
      step(32'h0004_0000, 0, 0, 0, 0, 0, "R8 higher no ack");
      step(32'h0004_0000, 0, 0, 1, 0, 0, "R8 ack edge");
      step(32'h0004_0000, 0, 0, 0, 0, 0, "R2 bit18 level15 after ack");
      step(0, 0, 0, 1, 0, 0, "R8 ack");
      // R4/R5: highest software bit wins, summary carries both
      step(32'h0000_0220, 0, 0, 0, 0, 0, "R4 sw highest R5 summary");
      step(0, 0, 0, 1, 0, 0, "R8 ack");
      // R4: external overrides software
      step(32'h0004_0000, 32'h0010_0000, 0, 0, 0, 0, "R4 ext over sw R5");
      step(0, 0, 0, 1, 0, 0, "R8 ack");
      // R3: top external bit, lower external bits ignored
      step(0, 32'h8000_FFFF, 0, 0, 0, 0, "R3 ext bit31");
      step(0, 0, 0, 1, 0, 0, "R8 ack");
      step(0, 32'h000F_0000, 0, 0, 0, 0, "R3 ext below range ignored");
      // R9: write keeps low 5 bits, R6 equal level no trap
      step(0, 0, 0, 0, 1, 32'hFFFF_FF2E, "R9 ipl write");
      step(32'h0002_0000, 0, 0, 0, 0, 0, "R6 equal level no trap");
      step(32'h0004_0000, 0, 0, 0, 0, 0, "R6 above level trap");
      step(0, 0, 0, 1, 0, 0, "R8 ack");
      step(0, 32'h0010_0000, 0, 0, 1, 32'h0000_0015, "R9 write same cycle old ipl");
      step(0, 32'h0020_0000, 0, 1, 0, 0, "R6 level 21 vs 21 no trap");
      step(0, 32'h0040_0000, 0, 0, 0, 0, "R6 level 22 trap");
      step(0, 0, 0, 1, 1, 0, "R9 clear ipl");
      // R10: async request flag
      step(0, 0, 4'b0100, 0, 0, 0, "R10 async set");
      step(0, 0, 4'b0000, 0, 0, 0, "R10 async clear");
      step(0, 0, 4'b1000, 0, 0, 0, "R10 async top bit");
      step(0, 0, 0, 0, 0, 0, "R7 idle tail");
      @(negedge clk);
      @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule